// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block drives one pulse-width-modulated output from two 32-bit registers reached over a plain write strobe with a combinational read path. A prescaler turns the input clock into a slower tick. A tick counter then walks through one period, drives the programmed active level for the first part of it and the opposite level for the rest. The block can repeat this period without end, or emit exactly one period each time software fires it.

Period values are double-buffered. A write lands in a shadow copy and raises a pending flag. The working counters take the new value only at a period boundary, or at once when the channel is idle, so a running waveform never shows a torn period. Software polls the pending flag before it writes the next value.

Top module: `pwm_chan`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is 1, which is the inactive level when the level bit is 0.
- R2: Offset 0x00 is control. It reads back the divider select in bits 3:0, enable in bit 4, active level in bit 5, tick gate in bit 6, one-shot mode in bit 7, fire in bit 8, bypass in bit 9 and the read-only pending flag in bit 28. Offset 0x04 is the period register: total ticks minus one in bits 31:16 and active ticks in bits 15:0.
- R3: In continuous mode the counter starts from zero on the cycle after it begins running. The output is active for the first `active` ticks and the period lasts `total_m1 + 1` ticks, repeating without a gap.
- R4: A level bit of 1 makes the active part drive 1. A level bit of 0 makes it drive 0, and the inactive part drives the complement.
- R5: An active count of 0 keeps the output inactive for the whole period. An active count of at least `total_m1 + 1` keeps it active for the whole period.
- R6: The counters run only while both the enable bit and the gate bit are 1. Otherwise the output is inactive and the counters return to zero, so the next start begins a fresh period.
- R7: A period write sets bit 28. The shadow value is loaded at the end of the current period while running, or on the next clock while not running, and bit 28 clears on that load.
- R8: With bit 7 set, the output stays inactive until a control write sets bit 8. Exactly one period is then emitted and bit 8 clears itself. Bit 8 written while bit 7 is 0 reads back 0.
- R9: The divider select gives one tick every N clocks: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, and every other code →1.
- R10: With bit 9 set the prescaler is bypassed and a tick occurs on every input clock, whatever the divider select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| pwm_out | output | 1 | Waveform output |

## Verification
The hardest situation to reach is a period write that arrives while a waveform is running. The new value must wait out the rest of the current period, and the pending flag must stay visible for exactly that long. The stimulus starts the channel and issues the period write on the very next clock, so the point of the write within the period is known. The expected stream then holds the tail of the old period followed by the new waveform, and the pending bit is read both just after the write and after the swap.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   localparam int CTL_OFS   = 0;
   localparam int PER_OFS   = 4;
   localparam int PEND_BIT  = 28;
   localparam int DIV_MAX_W = 17;

   typedef struct packed {
      logic       bypass;
      logic       fire;
      logic       one_shot;
      logic       gate;
      logic       level;
      logic       run_en;
      logic [3:0] div_sel;
   } pwm_ctl_t;

   function automatic logic [DIV_MAX_W-1:0] div_of(input logic [3:0] sel);
      logic [DIV_MAX_W-1:0] d;
      case (sel)
         4'd0:    d = 17'd120;
         4'd1:    d = 17'd180;
         4'd2:    d = 17'd240;
         4'd3:    d = 17'd360;
         4'd4:    d = 17'd480;
         4'd8:    d = 17'd12000;
         4'd9:    d = 17'd24000;
         4'd10:   d = 17'd36000;
         4'd11:   d = 17'd48000;
         4'd12:   d = 17'd72000;
         default: d = 17'd1;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load_now,
   input  logic              pulse_done,
   output pwm_ctl_t          ctl,
   output logic [CNT_W-1:0]  sh_span,
   output logic [CNT_W-1:0]  sh_hi,
   output logic              pend,
   output logic              wr_ctl,
   output logic              wr_per,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
   localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(PER_OFS);

   assign wr_ctl = wr_en && (addr == A_CTL);
   assign wr_per = wr_en && (addr == A_PER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_ctl) begin
         ctl.div_sel  <= wdata[3:0];
         ctl.run_en   <= wdata[4];
         ctl.level    <= wdata[5];
         ctl.gate     <= wdata[6];
         ctl.one_shot <= wdata[7];
         ctl.fire     <= wdata[8] & wdata[7];
         ctl.bypass   <= wdata[9];
      end else if (pulse_done) begin
         ctl.fire <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_span <= '0;
         sh_hi   <= '0;
         pend    <= 1'b0;
      end else if (wr_per) begin
         sh_span <= wdata[CNT_W +: CNT_W];
         sh_hi   <= wdata[0 +: CNT_W];
         pend    <= 1'b1;
      end else if (load_now) begin
         pend <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTL) begin
         rdata[3:0]      = ctl.div_sel;
         rdata[4]        = ctl.run_en;
         rdata[5]        = ctl.level;
         rdata[6]        = ctl.gate;
         rdata[7]        = ctl.one_shot;
         rdata[8]        = ctl.fire;
         rdata[9]        = ctl.bypass;
         rdata[PEND_BIT] = pend;
      end else if (addr == A_PER) begin
         rdata[CNT_W +: CNT_W] = sh_span;
         rdata[0 +: CNT_W]     = sh_hi;
      end
   end

endmodule

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale
   import pwm_chan_pkg::*;
#(
   parameter int DIV_W = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       bypass,
   input  logic [3:0] div_sel,
   output logic       tick
);

   logic [DIV_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_m1;

   assign div_m1 = bypass ? '0 : DIV_W'(div_of(div_sel) - 1'b1);
   assign tick   = run && (pre_cnt >= div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pre_cnt <= '0;
      else if (!run || tick) pre_cnt <= '0;
      else                   pre_cnt <= pre_cnt + 1'b1;
   end

endmodule

// File: rtl/pwm_chan_wave.sv
module pwm_chan_wave #(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             level,
   input  logic             pend,
   input  logic [CNT_W-1:0] sh_span,
   input  logic [CNT_W-1:0] sh_hi,
   output logic             load_now,
   output logic             period_end,
   output logic [CNT_W-1:0] hi_live,
   output logic             pwm_out
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] span_live;
   logic             wave_c;

   assign period_end = tick && (cnt == span_live);
   assign load_now   = pend && (!run || period_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!run || period_end) cnt <= '0;
      else if (tick)               cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span_live <= '0;
         hi_live   <= '0;
      end else if (load_now) begin
         span_live <= sh_span;
         hi_live   <= sh_hi;
      end
   end

   assign wave_c = (run && (cnt < hi_live)) ? level : ~level;

   if (OUT_REG) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b1;
         else        out_q <= wave_c;
      end
      assign pwm_out = out_q;
   end else begin : g_out_comb
      assign pwm_out = wave_c;
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 16,
   parameter int DIV_W   = 17,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out
);

   if (2 * CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_chan: two CNT_W fields must fit in DATA_W");
   end
   if (DATA_W <= PEND_BIT) begin : g_bad_data
      $error("pwm_chan: DATA_W too small for the pending bit");
   end
   if (DIV_W < DIV_MAX_W) begin : g_bad_div
      $error("pwm_chan: DIV_W cannot hold the largest divider");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pwm_chan: ADDR_W must reach offset 4");
   end

   pwm_ctl_t         ctl;
   logic [CNT_W-1:0] sh_span;
   logic [CNT_W-1:0] sh_hi;
   logic [CNT_W-1:0] hi_live;
   logic             pend;
   logic             wr_ctl;
   logic             wr_per;
   logic             load_now;
   logic             period_end;
   logic             pulse_done;
   logic             tick;
   logic             run;

   assign run        = ctl.run_en && ctl.gate && (!ctl.one_shot || ctl.fire);
   assign pulse_done = ctl.one_shot && period_end;

   pwm_chan_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .load_now  (load_now),
      .pulse_done(pulse_done),
      .ctl       (ctl),
      .sh_span   (sh_span),
      .sh_hi     (sh_hi),
      .pend      (pend),
      .wr_ctl    (wr_ctl),
      .wr_per    (wr_per),
      .rdata     (rdata)
   );

   pwm_chan_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .bypass (ctl.bypass),
      .div_sel(ctl.div_sel),
      .tick   (tick)
   );

   pwm_chan_wave #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .level     (ctl.level),
      .pend      (pend),
      .sh_span   (sh_span),
      .sh_hi     (sh_hi),
      .load_now  (load_now),
      .period_end(period_end),
      .hi_live   (hi_live),
      .pwm_out   (pwm_out)
   );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             level,
   input logic             pend,
   input logic             wr_per,
   input logic             wr_ctl,
   input logic             pulse_done,
   input logic             fire,
   input logic [CNT_W-1:0] hi_live,
   input logic             pwm_out
);

   // R7: a period write always leaves the pending flag set
   a_r7_write_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      wr_per |=> pend);

   // R7: when idle, a pending value is taken on the next clock
   a_r7_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !run && !wr_per) |=> !pend);

   // R8: the fire bit drops after the single period
   a_r8_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_done && !wr_ctl) |=> !fire);

   if (!OUT_REG) begin : g_comb_checks
      // R6: not running means inactive output
      a_r6_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
         !run |-> (pwm_out == !level));

      // R5: zero active ticks means inactive output
      a_r5_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
         (hi_live == '0) |-> (pwm_out == !level));
   end

endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .level     (ctl.level),
   .pend      (pend),
   .wr_per    (wr_per),
   .wr_ctl    (wr_ctl),
   .pulse_done(pulse_done),
   .fire      (ctl.fire),
   .hi_live   (hi_live),
   .pwm_out   (pwm_out)
);

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;

   typedef struct {
      logic  val;
      string req;
   } exp_t;

   localparam logic [31:0] EN   = 32'h10;
   localparam logic [31:0] LVL  = 32'h20;
   localparam logic [31:0] GATE = 32'h40;
   localparam logic [31:0] MODE = 32'h80;
   localparam logic [31:0] FIRE = 32'h100;
   localparam logic [31:0] BYP  = 32'h200;
   localparam logic [31:0] DIV1 = 32'hF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm_out;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   pwm_chan u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0; addr = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata; addr = '0;
   endtask

   task automatic push(input logic v, input int n, input string req);
      for (int i = 0; i < n; i++) q.push_back('{v, req});
   endtask

   task automatic push_wave(input int hi, input int span, input logic lvl,
                            input int reps, input string req);
      for (int r = 0; r < reps; r++)
         for (int i = 0; i < span; i++) push((i < hi) ? lvl : ~lvl, 1, req);
   endtask

   task automatic drain;
      while (q.size() != 0) begin @(posedge clk); #1; end
   endtask

   task automatic step;
      @(posedge clk); #1;
   endtask

   // monitor: compare each expected item against the output
   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (pwm_out !== e.val) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b expected %0b", e.req, pwm_out, e.val);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      step();

      // R1 reset state
      rd(8'h0, v); chk(v, 32'h0, "R1 ctrl");
      rd(8'h4, v); chk(v, 32'h0, "R1 period");
      chk({31'b0, pwm_out}, 32'h1, "R1 out");

      // R7 idle load, R2 period readback
      wr(8'h4, {16'd4, 16'd2});
      rd(8'h0, v); chk({31'b0, v[28]}, 32'h1, "R7 pend set");
      step();
      rd(8'h0, v); chk({31'b0, v[28]}, 32'h0, "R7 pend idle clear");
      rd(8'h4, v); chk(v, {16'd4, 16'd2}, "R2 period readback");

      // R3 continuous waveform
      wr(8'h0, EN | GATE | LVL | DIV1);
      push_wave(2, 5, 1'b1, 3, "R3");
      drain();
      rd(8'h0, v); chk(v, EN | GATE | LVL | DIV1, "R2 ctrl readback");

      // R6 needs both enable and gate
      wr(8'h0, LVL | DIV1);        push(1'b0, 6, "R6 no enable"); drain();
      wr(8'h0, EN | LVL | DIV1);   push(1'b0, 6, "R6 no gate");   drain();

      // R7 period write while running
      wr(8'h0, EN | GATE | LVL | DIV1);
      push(1'b1, 1, "R7 old period");
      wr(8'h4, {16'd2, 16'd1});
      rd(8'h0, v); chk({31'b0, v[28]}, 32'h1, "R7 pend while running");
      push(1'b1, 1, "R7 old period");
      push(1'b0, 3, "R7 old period");
      push_wave(1, 3, 1'b1, 2, "R7 new period");
      drain();
      rd(8'h0, v); chk({31'b0, v[28]}, 32'h0, "R7 pend after swap");
      wr(8'h0, LVL | DIV1);

      // R5 zero and full active counts
      wr(8'h4, {16'd3, 16'd0}); step();
      wr(8'h0, EN | GATE | LVL | DIV1); push(1'b0, 8, "R5 zero"); drain();
      wr(8'h0, LVL | DIV1);
      wr(8'h4, {16'd3, 16'd9}); step();
      wr(8'h0, EN | GATE | LVL | DIV1); push(1'b1, 8, "R5 full"); drain();
      wr(8'h0, LVL | DIV1);

      // R4 active-low level, then R6 inactive high when off
      wr(8'h4, {16'd4, 16'd2}); step();
      wr(8'h0, EN | GATE | DIV1); push_wave(2, 5, 1'b0, 2, "R4"); drain();
      wr(8'h0, DIV1); push(1'b1, 3, "R6 off low-level"); drain();

      // R8 one-shot
      wr(8'h0, EN | GATE | LVL | MODE | DIV1); push(1'b0, 6, "R8 armed"); drain();
      wr(8'h0, EN | GATE | LVL | MODE | FIRE | DIV1);
      rd(8'h0, v); chk({31'b0, v[8]}, 32'h1, "R8 fire set");
      push_wave(2, 5, 1'b1, 1, "R8 pulse");
      push(1'b0, 6, "R8 after pulse");
      drain();
      rd(8'h0, v); chk({31'b0, v[8]}, 32'h0, "R8 fire cleared");
      wr(8'h0, EN | GATE | LVL | FIRE | DIV1);
      rd(8'h0, v); chk({31'b0, v[8]}, 32'h0, "R8 fire ignored in cycle mode");
      wr(8'h0, LVL | DIV1);

      // R9 prescaler codes 0 and 1
      wr(8'h4, {16'd1, 16'd1}); step();
      wr(8'h0, EN | GATE | LVL);
      push(1'b1, 120, "R9 div120"); push(1'b0, 120, "R9 div120");
      push(1'b1, 120, "R9 div120");
      drain();
      wr(8'h0, LVL);
      wr(8'h0, EN | GATE | LVL | 32'h1);
      push(1'b1, 180, "R9 div180"); push(1'b0, 180, "R9 div180");
      drain();
      wr(8'h0, LVL);

      // R10 bypass
      wr(8'h0, EN | GATE | LVL | BYP);
      push_wave(1, 2, 1'b1, 3, "R10");
      drain();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule